// File: doc/BRIEF.md
# Zero-Current Sort-Mode Scheduler

This block tells a cell-sorting modulator of a cascaded H-bridge phase leg, for each half of every control cycle, whether to rank its cells for charging or for discharging. It turns carrier peak and valley pulses into a main interrupt. It also places a secondary interrupt halfway between two main interrupts, using the spacing it measured between the last two main events. At every main interrupt it picks the mode for the cycle that starts. Its inputs for that choice are an RMS current magnitude (already measured, fixed-point per unit), the sign of the phase current, the sign of the voltage reference and a bit that says whether the controller runs with one sample of delay.

When the RMS current lies below a programmable threshold, the leg is in standby. The measured current sign then tells nothing useful, so the block ignores it and imposes a fixed two-part pattern within the cycle. Without delay, the first half discharges and the second half charges. With delay, the two halves are swapped, and the change happens at the secondary interrupt. Outside that window the mode is chosen once per cycle from the two signs, and the secondary interrupt leaves it alone. Every mode evaluation is announced to the modulator by a one-clock update strobe.

Top module: `sort_mode_sched`

## Requirements
- R1: A pulse on `carrier_top` or `carrier_bot` (or both in one clock) gives a one-clock `main_irq` pulse in the following clock, and `main_irq` never rises otherwise.
- R2: Once two main events have occurred, `sec_irq` pulses once, floor(P/2) clocks after each `main_irq`. Here P is the number of clocks between the two most recent carrier events. It does not pulse if P/2 is zero, or if the next carrier event arrives at or before that point. There is no `sec_irq` after the first main event following reset. `sec_irq` and `main_irq` are never high together.
- R3: Standby (`zc_active` = 1) is decided in the clock that `main_irq` is high, by the unsigned compare `irms_pu < threshold`. `zc_active` changes only in the clock after `main_irq`.
- R4: In standby with `delay_cfg` = 0 at the main event, the first half of the cycle uses discharge (`mode_chg` = 0). From the clock after `sec_irq`, it uses charge (`mode_chg` = 1).
- R5: In standby with `delay_cfg` = 1 at the main event, the first half uses charge and the second half uses discharge.
- R6: Outside standby, `mode_chg` becomes 1 when `cur_neg` equals `vref_neg` at the main event (1 means negative) and 0 otherwise.
- R7: Outside standby, `sec_irq` gives no update strobe and leaves `mode_chg` unchanged.
- R8: `mode_upd` is a one-clock pulse in the clock after each `main_irq`, and in the clock after each `sec_irq` that falls in a standby cycle. `mode_chg` changes only together with `mode_upd`.
- R9: The threshold resets to `THR_RESET` (983, about 0.03 in Q1.15 per unit) and is loaded from `thr_wdata` in the clock `thr_we` is high. A new value is first used at the next main event.
- R10: In standby the current and voltage signs are ignored. Changes to the signs, `irms_pu` and `delay_cfg` between main events have no effect on `mode_chg` or `zc_active`.
- R11: While `rst_n` is low, all outputs are 0 (discharge, no standby, no pulses).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| carrier_top | input | 1 | One-clock pulse at the carrier peak |
| carrier_bot | input | 1 | One-clock pulse at the carrier valley |
| irms_pu | input | DATA_W | RMS phase current magnitude, unsigned per unit, same scale as the threshold |
| cur_neg | input | 1 | Phase current is negative |
| vref_neg | input | 1 | Voltage reference is negative |
| delay_cfg | input | 1 | Controller runs with one sample of delay |
| thr_we | input | 1 | Load the standby threshold |
| thr_wdata | input | DATA_W | New standby threshold |
| main_irq | output | 1 | Main interrupt pulse |
| sec_irq | output | 1 | Mid-cycle interrupt pulse |
| mode_chg | output | 1 | 1 = rank for charging, 0 = rank for discharging |
| mode_upd | output | 1 | One-clock strobe: mode has just been evaluated |
| zc_active | output | 1 | Current cycle runs the standby pattern |

## Verification
`main_irq` is due one clock after a carrier pulse. `mode_chg`, `mode_upd` and `zc_active` follow one clock later. `sec_irq` comes floor(P/2) clocks after `main_irq`, and the second-half mode and its strobe one clock after that. The bench drives inputs on the falling edge and counts falling edges from each carrier pulse. It predicts each output at its exact offset from the previous interval and the sampled inputs, then compares at every falling edge of the cycle. Because of that, a strobe or mode change that comes one clock early or late, or that has no cause, is caught. Random intervals are kept clear of the one offset where the second-half strobe would land on the next cycle's main interrupt, while long-then-short intervals test the dropped secondary interrupt.

// File: rtl/sms_pkg.sv
package sms_pkg;

  typedef enum logic {
    SORT_DIS = 1'b0,
    SORT_CHG = 1'b1
  } sort_mode_e;

  // Mode outside standby: charging when reference and current share a sign.
  function automatic sort_mode_e normal_mode(input logic vref_neg, input logic cur_neg);
    return (vref_neg == cur_neg) ? SORT_CHG : SORT_DIS;
  endfunction

  // Standby pattern: discharge then charge, swapped when the loop has delay.
  function automatic sort_mode_e standby_mode(input logic dly, input logic second_half);
    return (dly ^ second_half) ? SORT_CHG : SORT_DIS;
  endfunction

endpackage

// File: rtl/sms_evt_timer.sv
module sms_evt_timer #(
  parameter int CNT_W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_in,
  output logic main_irq,
  output logic sec_irq
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] since_evt;
  logic [CNT_W-1:0] period_q;
  logic [CNT_W-1:0] half_pt;
  logic             seen_one;
  logic             period_ok;
  logic             sec_done;
  logic             sec_hit;

  assign half_pt = period_q >> 1;
  assign sec_hit = period_ok && !sec_done && !evt_in &&
                   (half_pt != '0) && (since_evt == half_pt - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_evt <= '0;
      period_q  <= '0;
      seen_one  <= 1'b0;
      period_ok <= 1'b0;
      sec_done  <= 1'b0;
      main_irq  <= 1'b0;
      sec_irq   <= 1'b0;
    end else begin
      main_irq <= evt_in;
      sec_irq  <= sec_hit;
      if (evt_in) begin
        period_q  <= (since_evt == CNT_MAX) ? CNT_MAX : since_evt + 1'b1;
        period_ok <= seen_one;
        seen_one  <= 1'b1;
        since_evt <= '0;
        sec_done  <= 1'b0;
      end else begin
        if (since_evt != CNT_MAX) since_evt <= since_evt + 1'b1;
        if (sec_hit) sec_done <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/sms_thr_reg.sv
module sms_thr_reg #(
  parameter int DATA_W = 16,
  parameter logic [DATA_W-1:0] THR_RESET = 16'd983
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              thr_we,
  input  logic [DATA_W-1:0] thr_wdata,
  output logic [DATA_W-1:0] thr_q
);

  always_ff @(posedge clk) begin
    if (!rst_n)      thr_q <= THR_RESET;
    else if (thr_we) thr_q <= thr_wdata;
  end

endmodule

// File: rtl/sms_mode_ctrl.sv
module sms_mode_ctrl
  import sms_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              main_irq,
  input  logic              sec_irq,
  input  logic [DATA_W-1:0] irms_pu,
  input  logic [DATA_W-1:0] thr_q,
  input  logic              cur_neg,
  input  logic              vref_neg,
  input  logic              delay_cfg,
  output sort_mode_e        mode_q,
  output logic              mode_upd,
  output logic              zc_q,
  output logic              dly_q
);

  logic in_window;
  assign in_window = (irms_pu < thr_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= SORT_DIS;
      mode_upd <= 1'b0;
      zc_q     <= 1'b0;
      dly_q    <= 1'b0;
    end else if (main_irq) begin
      zc_q     <= in_window;
      dly_q    <= delay_cfg;
      mode_q   <= in_window ? standby_mode(delay_cfg, 1'b0)
                            : normal_mode(vref_neg, cur_neg);
      mode_upd <= 1'b1;
    end else if (sec_irq && zc_q) begin
      mode_q   <= standby_mode(dly_q, 1'b1);
      mode_upd <= 1'b1;
    end else begin
      mode_upd <= 1'b0;
    end
  end

endmodule

// File: rtl/sort_mode_sched.sv
module sort_mode_sched
  import sms_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16,
  parameter logic [DATA_W-1:0] THR_RESET = 16'd983
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              carrier_top,
  input  logic              carrier_bot,
  input  logic [DATA_W-1:0] irms_pu,
  input  logic              cur_neg,
  input  logic              vref_neg,
  input  logic              delay_cfg,
  input  logic              thr_we,
  input  logic [DATA_W-1:0] thr_wdata,
  output logic              main_irq,
  output logic              sec_irq,
  output logic              mode_chg,
  output logic              mode_upd,
  output logic              zc_active
);

  logic              evt_any;
  logic              main_evt;
  logic              sec_evt;
  logic [DATA_W-1:0] thr_q;
  sort_mode_e        mode_q;
  logic              cyc_delay;

  assign evt_any = carrier_top | carrier_bot;

  sms_evt_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_in   (evt_any),
    .main_irq (main_evt),
    .sec_irq  (sec_evt)
  );

  sms_thr_reg #(.DATA_W(DATA_W), .THR_RESET(THR_RESET)) u_thr (
    .clk       (clk),
    .rst_n     (rst_n),
    .thr_we    (thr_we),
    .thr_wdata (thr_wdata),
    .thr_q     (thr_q)
  );

  sms_mode_ctrl #(.DATA_W(DATA_W)) u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .main_irq  (main_evt),
    .sec_irq   (sec_evt),
    .irms_pu   (irms_pu),
    .thr_q     (thr_q),
    .cur_neg   (cur_neg),
    .vref_neg  (vref_neg),
    .delay_cfg (delay_cfg),
    .mode_q    (mode_q),
    .mode_upd  (mode_upd),
    .zc_q      (zc_active),
    .dly_q     (cyc_delay)
  );

  assign main_irq = main_evt;
  assign sec_irq  = sec_evt;
  assign mode_chg = (mode_q == SORT_CHG);

endmodule

// File: rtl/sms_checker.sv
module sms_checker (
  input logic clk,
  input logic rst_n,
  input logic carrier_top,
  input logic carrier_bot,
  input logic main_irq,
  input logic sec_irq,
  input logic mode_chg,
  input logic mode_upd,
  input logic zc_active,
  input logic cyc_delay
);

  p_main_follows_evt_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (carrier_top || carrier_bot) |=> main_irq);

  p_main_has_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
    main_irq |-> $past(carrier_top || carrier_bot));

  p_irq_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(main_irq && sec_irq));

  p_zc_moves_at_main_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(zc_active) |-> $past(main_irq));

  p_standby_second_chg_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_irq && zc_active && !cyc_delay) |=> (mode_chg && mode_upd));

  p_standby_second_dis_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_irq && zc_active && cyc_delay) |=> (!mode_chg && mode_upd));

  p_normal_sec_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_irq && !zc_active) |=> (!mode_upd && $stable(mode_chg)));

  p_strobe_after_main_r8: assert property (@(posedge clk) disable iff (!rst_n)
    main_irq |=> mode_upd);

  p_mode_moves_with_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_chg) |-> mode_upd);

endmodule

bind sort_mode_sched sms_checker u_sms_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .carrier_top (carrier_top),
  .carrier_bot (carrier_bot),
  .main_irq    (main_irq),
  .sec_irq     (sec_irq),
  .mode_chg    (mode_chg),
  .mode_upd    (mode_upd),
  .zc_active   (zc_active),
  .cyc_delay   (cyc_delay)
);

// File: tb/sort_mode_sched_tb_top.sv
module sort_mode_sched_tb_top;

  localparam int DATA_W = 16;
  localparam int THR0   = 983;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              carrier_top = 1'b0;
  logic              carrier_bot = 1'b0;
  logic [DATA_W-1:0] irms_pu = '0;
  logic              cur_neg = 1'b0;
  logic              vref_neg = 1'b0;
  logic              delay_cfg = 1'b0;
  logic              thr_we = 1'b0;
  logic [DATA_W-1:0] thr_wdata = '0;
  logic              main_irq, sec_irq, mode_chg, mode_upd, zc_active;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // bench model state
  int thr_m    = THR0;
  int prev_d   = 0;
  int n_evt    = 0;
  bit exp_mode = 0;
  bit exp_zc   = 0;
  bit use_top  = 1;

  always #2 clk = ~clk;  // 250 MHz

  sort_mode_sched #(.DATA_W(DATA_W), .CNT_W(16), .THR_RESET(16'(THR0))) dut_i (
    .clk(clk), .rst_n(rst_n), .carrier_top(carrier_top), .carrier_bot(carrier_bot),
    .irms_pu(irms_pu), .cur_neg(cur_neg), .vref_neg(vref_neg), .delay_cfg(delay_cfg),
    .thr_we(thr_we), .thr_wdata(thr_wdata), .main_irq(main_irq), .sec_irq(sec_irq),
    .mode_chg(mode_chg), .mode_upd(mode_upd), .zc_active(zc_active)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  // Expected mode functions, written from the requirements.
  function automatic bit first_half_mode(bit zc, bit dly, bit ineg, bit vneg);
    if (zc) return dly;              // R4: discharge first, R5: charge first
    return (ineg == vneg) ? 1'b1 : 1'b0;  // R6
  endfunction

  function automatic bit second_half_mode(bit dly);
    return dly ? 1'b0 : 1'b1;
  endfunction

  // One control interval of d clocks starting at the current falling edge.
  task automatic run_cycle(input int d, input int irms_v, input bit ineg, input bit vneg,
                           input bit dly, input bit scramble, input int new_thr, input bit both);
    int  half;
    bit  sec_exp;
    bit  zc;
    bit  upd_exp;
    string mreq;
    half    = (n_evt >= 1) ? prev_d / 2 : 0;
    sec_exp = (n_evt >= 1) && (half >= 1) && (half < d);
    zc      = (irms_v < thr_m);
    carrier_top = both ? 1'b1 : use_top;
    carrier_bot = both ? 1'b1 : !use_top;
    use_top     = !use_top;
    irms_pu   = DATA_W'(irms_v);
    cur_neg   = ineg;
    vref_neg  = vneg;
    delay_cfg = dly;
    for (int k = 1; k <= d; k++) begin
      @(negedge clk);
      if (k == 1) begin
        carrier_top = 1'b0;
        carrier_bot = 1'b0;
      end
      mreq = "R10";
      if (k == 2) begin
        exp_mode = first_half_mode(zc, dly, ineg, vneg);
        exp_zc   = zc;
        mreq     = zc ? (dly ? "R5" : "R4") : "R6";
      end
      if (zc && sec_exp && k == half + 2) begin
        exp_mode = second_half_mode(dly);
        mreq     = dly ? "R5" : "R4";
      end
      upd_exp = (k == 2) || (zc && sec_exp && k == half + 2);
      check("R1", "main_irq", int'(main_irq), int'(k == 1));
      check("R2", "sec_irq", int'(sec_irq), int'(sec_exp && k == half + 1));
      check((!zc && k == half + 2) ? "R7" : "R8", "mode_upd", int'(mode_upd), int'(upd_exp));
      check(mreq, "mode_chg", int'(mode_chg), int'(exp_mode));
      if (k >= 2) check("R3", "zc_active", int'(zc_active), int'(exp_zc));
      if (k >= 2 && scramble) begin
        cur_neg   = 1'($urandom);
        vref_neg  = 1'($urandom);
        delay_cfg = 1'($urandom);
        irms_pu   = DATA_W'($urandom);
      end
      if (k == 3 && new_thr >= 0) begin
        thr_we    = 1'b1;
        thr_wdata = DATA_W'(new_thr);
      end
      if (k == 4 && new_thr >= 0) begin
        thr_we = 1'b0;
        thr_m  = new_thr;  // R9: used from the next main event on
      end
    end
    prev_d = d;
    n_evt++;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int d, iv;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11", "mode_chg in reset", int'(mode_chg), 0);
    check("R11", "zc_active in reset", int'(zc_active), 0);
    check("R11", "strobes in reset", int'({main_irq, sec_irq, mode_upd}), 0);
    rst_n = 1'b1;
    repeat (4) begin
      @(negedge clk);
      check("R11", "idle outputs after reset", int'({main_irq, sec_irq, mode_upd, mode_chg, zc_active}), 0);
    end
    // First event: no interval yet (R2), normal mode R6
    run_cycle(12, 2000, 1'b0, 1'b0, 1'b0, 1'b0, -1, 1'b0);
    run_cycle(12, 2000, 1'b1, 1'b0, 1'b0, 1'b0, -1, 1'b0);
    // Standby, no delay (R4), signs ignored (R10)
    run_cycle(12, 100, 1'b0, 1'b0, 1'b0, 1'b1, -1, 1'b0);
    run_cycle(11, 100, 1'b1, 1'b0, 1'b0, 1'b1, -1, 1'b0);
    // Standby with delay (R5)
    run_cycle(10, 0, 1'b0, 1'b1, 1'b1, 1'b1, -1, 1'b0);
    // R3 boundaries: equal is outside, one below is inside
    run_cycle(10, THR0, 1'b0, 1'b0, 1'b0, 1'b0, -1, 1'b0);
    run_cycle(10, THR0 - 1, 1'b0, 1'b0, 1'b0, 1'b0, -1, 1'b0);
    // Both carrier inputs at once still one main event (R1)
    run_cycle(10, 50, 1'b0, 1'b0, 1'b1, 1'b0, -1, 1'b1);
    // R9: threshold written to zero -> never standby, then raised
    run_cycle(10, 0, 1'b0, 1'b0, 1'b0, 1'b0, 0, 1'b0);
    run_cycle(10, 0, 1'b1, 1'b1, 1'b0, 1'b0, 5000, 1'b0);
    run_cycle(10, 4999, 1'b1, 1'b1, 1'b1, 1'b0, -1, 1'b0);
    // R2: long interval then short one drops the mid event
    run_cycle(40, 10, 1'b0, 1'b0, 1'b0, 1'b0, -1, 1'b0);
    run_cycle(8, 10, 1'b0, 1'b0, 1'b0, 1'b0, -1, 1'b0);
    run_cycle(20, 10, 1'b0, 1'b0, 1'b1, 1'b0, -1, 1'b0);
    // Random mix (R2..R10)
    for (int n = 0; n < 300; n++) begin
      d = 5 + int'($urandom_range(35));
      if (prev_d / 2 == d - 1) d++;
      case ($urandom_range(3))
        0: iv = int'($urandom_range(65535));
        1: iv = thr_m + int'($urandom_range(6)) - 3;
        default: iv = int'($urandom_range(thr_m + 200));
      endcase
      if (iv < 0) iv = 0;
      if (iv > 65535) iv = 65535;
      run_cycle(d, iv, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                ($urandom_range(19) == 0) ? int'($urandom_range(6000)) : -1, 1'b0);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule